// File: doc/BRIEF.md
# Dish Control Bus Master

This block is the master side of a single-wire dish control bus. It drives a 22 kHz tone toward the low-noise block and a static polarisation level. It sends short messages and tone bursts by switching the tone on and off. When the host asks for a reply, it also captures the answer that arrives on a separate envelope input. The tone half-period is a host-programmable number of system clocks, so the block produces an exact 22 kHz square wave at any supported clock. Every other time interval is a whole number of tone half-periods.

The host talks to the block through a flat write port and a flat read port. It loads up to eight message bytes, sets the mode bits and then writes a command. Once the command is accepted, `busy` stays high through the transmission, any reply window and the silent guard interval that follows. The `done` and `err` flags are sticky until the next accepted command. Reply bytes, the reply byte count and the per-byte parity flags are read back from the read port.

Top module: `dish_bus_ctrl`

## Requirements
- R1: After reset, `tone_out`, `pol_out`, `busy`, `done` and `err` are 0. The reply count (read address 8) is 0, and the divider holds `DIV_INIT`.
- R2: A tick occurs on every clock in which the prescaler count is at least max(divider,1)−1, and the prescaler then restarts at 0. The divider is written at address 0x8 (low byte) and 0x9 (high byte). While idle with continuous mode on (bit 0 of address 0xA), `tone_out` toggles on every tick. With continuous mode off, `tone_out` is cleared on the next tick.
- R3: `pol_out` takes bit 1 of each write to address 0xA and changes at no other time.
- R4: A write to address 0xB with field [7:6] = 01 while idle sends bytes 0..n from the transmit buffer (addresses 0x0–0x7), where n = field [2:0]. Each byte goes out MSB first and is followed by one odd-parity bit. A slot is `SLOT_HALVES` ticks. A 0 bit is two slots of tone then one slot of silence. A 1 bit is one slot of tone then two slots of silence. On acceptance `tone_out` is cleared, and the first tick after acceptance raises it.
- R5: After a message that expects no reply, or after a burst, the line stays silent for `GAP_SLOTS` slots with `busy` high. Then `busy` falls and `done` rises in the same cycle.
- R6: Command field 10 sends an unmodulated burst of `BURST_SLOTS` slots of tone. Command field 11 sends a modulated burst of nine 1-bits. Neither burst waits for a reply.
- R7: While `busy` is high, writes to the transmit buffer and command writes are ignored.
- R8: Continuous tone is suppressed from command acceptance until `busy` falls, and then resumes.
- R9: If bit 2 of address 0xA is set when a message command is accepted, the receiver is armed after the last bit. Each tone pulse on `rx_in` shorter than 1.5 slots decodes as 1, and a longer pulse decodes as 0. Every nine bits form a byte (MSB first) plus its parity bit. The byte is stored at read address 0x0–0x7 in arrival order, and the count is at read address 8.
- R10: A received byte whose nine bits hold an even number of ones sets its bit in the parity flag register (read address 9, bit i for byte i) and sets `err`.
- R11: A reply ends after `RX_END_SLOTS` slots of silence. Bytes after the eighth are dropped. A partial final byte is discarded and sets `err`. The guard interval then follows.
- R12: If no tone arrives within `REPLY_SLOTS` slots of the armed window, `err` is set and the guard interval follows, ending with `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 4 | Read address |
| rd_data | output | 8 | Read data (combinational) |
| busy | output | 1 | Command in progress, including reply window and guard |
| done | output | 1 | Last command finished (sticky) |
| err | output | 1 | Reply parity error, truncation or timeout (sticky) |
| tone_out | output | 1 | Gated tone square wave |
| pol_out | output | 1 | Polarisation level |
| rx_in | input | 1 | Reply tone envelope, high while tone present |

## Verification
A behavioural model in the bench holds a queue of expected tone gating, one entry per tick. Against it, the bench checks the tone, the polarisation level, `busy` and `done` on every clock. It goes after these corner cases:
- A divider change while the tone runs. A design that latched the divider late would shift every later edge.
- A start accepted while continuous tone is high. A design that kept the old phase would invert the whole message.
- A byte write and a command write issued in the middle of a message. A design that accepted either would alter the next transmission.
- Replies with a flipped parity bit, nine bytes, a trailing half byte and no reply at all. These catch a receiver that misses the error flag, overruns its buffer, keeps partial data or never times out.

// File: rtl/dish_bus_ctrl.sv
module dish_bus_ctrl #(
  parameter int SLOT_HALVES  = 22,
  parameter int GAP_SLOTS    = 30,
  parameter int BURST_SLOTS  = 25,
  parameter int RX_END_SLOTS = 12,
  parameter int REPLY_SLOTS  = 300,
  parameter logic [15:0] DIV_INIT = 16'd1136
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [3:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [3:0] rd_addr,
  output logic [7:0] rd_data,
  output logic       busy,
  output logic       done,
  output logic       err,
  output logic       tone_out,
  output logic       pol_out,
  input  logic       rx_in
);
  localparam int BIT_H   = 3 * SLOT_HALVES;
  localparam int GAP_H   = GAP_SLOTS * SLOT_HALVES;
  localparam int BURST_H = BURST_SLOTS * SLOT_HALVES;
  localparam int END_H   = RX_END_SLOTS * SLOT_HALVES;
  localparam int REPLY_H = REPLY_SLOTS * SLOT_HALVES;
  localparam int THR_H   = BIT_H / 2;
  localparam int CW      = $clog2(BIT_H + GAP_H + BURST_H + END_H + REPLY_H + 1);

  typedef enum logic [2:0] {S_IDLE, S_TX, S_BURST, S_WAIT, S_RX, S_GAP} st_t;

  st_t           st;
  logic [15:0]   div_q, pre_cnt;
  logic          cont_q, want_q, reply_q, bmod_q;
  logic [7:0]    txbuf [8];
  logic [7:0]    rxbuf [8];
  logic [7:0]    perr_q, rsh;
  logic [3:0]    rx_cnt, bit_i, rbits;
  logic [2:0]    bidx, last_q;
  logic [CW-1:0] half, hcnt, lcnt;
  logic          rx_m, rx_s, rx_d;
  logic          gate;

  wire [15:0] div_m1  = (div_q == 16'd0) ? 16'd0 : div_q - 16'd1;
  wire        tick    = pre_cnt >= div_m1;
  wire [1:0]  cmd_op  = wr_data[7:6];
  wire        start   = wr_en && wr_addr == 4'hB && cmd_op != 2'b00 && st == S_IDLE;
  wire [7:0]  cur_b   = bmod_q ? 8'hFF : txbuf[bidx];
  wire        cur_bit = bit_i[3] ? ~^cur_b : cur_b[3'd7 - bit_i[2:0]];
  wire [CW-1:0] tone_len = cur_bit ? CW'(SLOT_HALVES) : CW'(2 * SLOT_HALVES);
  wire        rx_rise = rx_s & ~rx_d;
  wire        rx_fall = ~rx_s & rx_d;
  wire        nb      = hcnt < CW'(THR_H);
  wire        bad_par = ~^{rsh, nb};

  assign busy = st != S_IDLE;

  always_comb begin
    case (st)
      S_IDLE:  gate = cont_q;
      S_TX:    gate = half < tone_len;
      S_BURST: gate = 1'b1;
      default: gate = 1'b0;
    endcase
  end

  always_comb begin
    if (!rd_addr[3]) rd_data = rxbuf[rd_addr[2:0]];
    else if (rd_addr[2:0] == 3'd0) rd_data = {4'd0, rx_cnt};
    else if (rd_addr[2:0] == 3'd1) rd_data = perr_q;
    else rd_data = 8'd0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt  <= '0;
      tone_out <= 1'b0;
      rx_m     <= 1'b0;
      rx_s     <= 1'b0;
      rx_d     <= 1'b0;
    end else begin
      pre_cnt <= tick ? 16'd0 : pre_cnt + 16'd1;
      rx_m    <= rx_in;
      rx_s    <= rx_m;
      rx_d    <= rx_s;
      if (start) tone_out <= 1'b0;
      else if (tick) tone_out <= gate ? ~tone_out : 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q   <= DIV_INIT;
      cont_q  <= 1'b0;
      pol_out <= 1'b0;
      want_q  <= 1'b0;
      for (int i = 0; i < 8; i++) txbuf[i] <= 8'd0;
    end else if (wr_en) begin
      if (wr_addr == 4'h8) div_q[7:0] <= wr_data;
      if (wr_addr == 4'h9) div_q[15:8] <= wr_data;
      if (wr_addr == 4'hA) begin
        cont_q  <= wr_data[0];
        pol_out <= wr_data[1];
        want_q  <= wr_data[2];
      end
      if (!wr_addr[3] && st == S_IDLE) txbuf[wr_addr[2:0]] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      half    <= '0;
      bit_i   <= '0;
      bidx    <= '0;
      last_q  <= '0;
      bmod_q  <= 1'b0;
      reply_q <= 1'b0;
      done    <= 1'b0;
      err     <= 1'b0;
      rx_cnt  <= '0;
      perr_q  <= '0;
      rsh     <= '0;
      rbits   <= '0;
      hcnt    <= '0;
      lcnt    <= '0;
      for (int i = 0; i < 8; i++) rxbuf[i] <= 8'd0;
    end else if (start) begin
      st      <= (cmd_op == 2'b10) ? S_BURST : S_TX;
      half    <= '0;
      bit_i   <= '0;
      bidx    <= '0;
      last_q  <= (cmd_op == 2'b01) ? wr_data[2:0] : 3'd0;
      bmod_q  <= cmd_op == 2'b11;
      reply_q <= (cmd_op == 2'b01) && want_q;
      done    <= 1'b0;
      err     <= 1'b0;
      rx_cnt  <= '0;
      perr_q  <= '0;
    end else begin
      case (st)
        S_TX: if (tick) begin
          if (half == CW'(BIT_H - 1)) begin
            half <= '0;
            if (bit_i == 4'd8) begin
              bit_i <= '0;
              if (bidx == last_q) st <= reply_q ? S_WAIT : S_GAP;
              else bidx <= bidx + 3'd1;
            end else begin
              bit_i <= bit_i + 4'd1;
            end
          end else begin
            half <= half + CW'(1);
          end
        end
        S_BURST: if (tick) begin
          if (half == CW'(BURST_H - 1)) begin
            st   <= S_GAP;
            half <= '0;
          end else begin
            half <= half + CW'(1);
          end
        end
        S_GAP: if (tick) begin
          if (half == CW'(GAP_H - 1)) begin
            st   <= S_IDLE;
            half <= '0;
            done <= 1'b1;
          end else begin
            half <= half + CW'(1);
          end
        end
        S_WAIT: begin
          if (rx_s) begin
            st    <= S_RX;
            hcnt  <= '0;
            lcnt  <= '0;
            rbits <= '0;
          end else if (tick) begin
            if (half == CW'(REPLY_H - 1)) begin
              err  <= 1'b1;
              st   <= S_GAP;
              half <= '0;
            end else begin
              half <= half + CW'(1);
            end
          end
        end
        S_RX: begin
          if (rx_rise) begin
            hcnt <= '0;
            lcnt <= '0;
          end else if (rx_fall) begin
            lcnt <= '0;
            if (rbits == 4'd8) begin
              rbits <= '0;
              if (rx_cnt < 4'd8) begin
                rxbuf[rx_cnt[2:0]]  <= rsh;
                perr_q[rx_cnt[2:0]] <= bad_par;
                if (bad_par) err <= 1'b1;
                rx_cnt <= rx_cnt + 4'd1;
              end
            end else begin
              rsh   <= {rsh[6:0], nb};
              rbits <= rbits + 4'd1;
            end
          end else if (tick) begin
            if (rx_s) begin
              if (hcnt < CW'(THR_H)) hcnt <= hcnt + CW'(1);
            end else if (lcnt == CW'(END_H - 1)) begin
              if (rbits != 4'd0) err <= 1'b1;
              st   <= S_GAP;
              half <= '0;
            end else begin
              lcnt <= lcnt + CW'(1);
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dish_bus_chk.sv
module dish_bus_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [3:0] wr_addr,
  input logic [7:0] wr_data,
  input logic       busy,
  input logic       done,
  input logic       err,
  input logic       tone_out,
  input logic       pol_out,
  input logic [2:0] st,
  input logic [3:0] rx_cnt
);
  localparam logic [2:0] K_IDLE = 3'd0;
  localparam logic [2:0] K_WAIT = 3'd3;
  localparam logic [2:0] K_RX   = 3'd4;

  a_r3_pol_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_addr == 4'hA) |=> $stable(pol_out));

  a_r5_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r4_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && wr_en && wr_addr == 4'hB && wr_data[7:6] != 2'b00) |=> busy);

  a_r9_quiet_listen: assert property (@(posedge clk) disable iff (!rst_n)
    (st == K_WAIT || st == K_RX) |-> !tone_out);

  a_r12_err_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> ($past(st) == K_WAIT || $past(st) == K_RX));

  a_r11_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (st == K_IDLE && !(wr_en && wr_addr == 4'hB)) |=> $stable(rx_cnt));

  a_r11_count_max: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cnt <= 4'd8);
endmodule

bind dish_bus_ctrl dish_bus_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .busy(busy), .done(done), .err(err), .tone_out(tone_out), .pol_out(pol_out),
  .st(st), .rx_cnt(rx_cnt)
);

// File: tb/sim_dish_bus_ctrl.sv
`timescale 1ns/1ps
module sim_dish_bus_ctrl;
  localparam int SL = 4, GP = 6, BU = 5, EN = 4, RP = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [3:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0;
  logic rx_in = 1'b0;
  logic [7:0] rd_data;
  logic busy, done, err, tone_out, pol_out;

  always #2 clk = ~clk;

  dish_bus_ctrl #(.SLOT_HALVES(SL), .GAP_SLOTS(GP), .BURST_SLOTS(BU),
                  .RX_END_SLOTS(EN), .REPLY_SLOTS(RP), .DIV_INIT(16'd2)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .done(done), .err(err),
    .tone_out(tone_out), .pol_out(pol_out), .rx_in(rx_in));

  int n_cmp = 0, n_bad = 0;
  task automatic chk(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference: one queue entry per expected tick of tone gating
  int m_div, m_pc, dm1;
  bit m_tone, m_pol, m_cont, m_exp, m_reply, m_done, tk, mbusy, g, st_acc;
  bit q[$];
  logic [7:0] m_tx [8];

  function automatic void push_bit(bit b);
    repeat (b ? SL : 2 * SL) q.push_back(1'b1);
    repeat (b ? 2 * SL : SL) q.push_back(1'b0);
  endfunction
  function automatic void push_byte(logic [7:0] v);
    for (int i = 7; i >= 0; i--) push_bit(v[i]);
    push_bit(~^v);
  endfunction
  function automatic void push_gap();
    repeat (GP * SL) q.push_back(1'b0);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_div = 2; m_pc = 0; m_tone = 0; m_pol = 0; m_cont = 0; m_exp = 0;
      m_reply = 0; m_done = 0; q.delete();
      for (int i = 0; i < 8; i++) m_tx[i] = 8'd0;
    end else begin
      dm1 = (m_div == 0) ? 0 : m_div - 1;
      tk = m_pc >= dm1;
      m_pc = tk ? 0 : m_pc + 1;
      mbusy = (q.size() != 0) || m_reply;
      g = (q.size() != 0) ? q[0] : (m_cont && !m_reply);
      st_acc = wr_en && wr_addr == 4'hB && wr_data[7:6] != 2'b00 && !mbusy;
      if (st_acc) m_tone = 0;
      else if (tk) m_tone = g ? !m_tone : 1'b0;
      if (tk && q.size() != 0) begin
        void'(q.pop_front());
        if (q.size() == 0 && !m_reply) m_done = 1;
      end
      if (m_reply && !busy) begin m_reply = 0; m_done = 1; end
      if (wr_en) begin
        if (wr_addr == 4'h8) m_div = (m_div & 32'hFF00) | int'(wr_data);
        if (wr_addr == 4'h9) m_div = (m_div & 32'h00FF) | (int'(wr_data) << 8);
        if (wr_addr == 4'hA) begin m_cont = wr_data[0]; m_pol = wr_data[1]; m_exp = wr_data[2]; end
        if (wr_addr < 4'h8 && !mbusy) m_tx[wr_addr[2:0]] = wr_data;
      end
      if (st_acc) begin
        m_done = 0;
        case (wr_data[7:6])
          2'b01: begin
            for (int i = 0; i <= int'(wr_data[2:0]); i++) push_byte(m_tx[i]);
            if (m_exp) m_reply = 1; else push_gap();
          end
          2'b10: begin repeat (BU * SL) q.push_back(1'b1); push_gap(); end
          default: begin push_byte(8'hFF); push_gap(); end
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2/R4/R6/R8 tone_out", int'(tone_out), int'(m_tone));
      chk("R3 pol_out", int'(pol_out), int'(m_pol));
      if (!m_reply) begin
        chk("R5/R7 busy", int'(busy), int'(q.size() != 0));
        chk("R5 done", int'(done), int'(m_done));
      end
    end
  end

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask
  task automatic rd(logic [3:0] a, output logic [7:0] d);
    @(negedge clk); rd_addr = a; #1 d = rd_data;
  endtask
  task automatic idle_wait();
    while (busy) @(negedge clk);
    repeat (6) @(negedge clk);
  endtask
  task automatic rx_bit(bit b);
    rx_in = 1'b1; repeat (b ? 8 : 16) @(negedge clk);
    rx_in = 1'b0; repeat (b ? 16 : 8) @(negedge clk);
  endtask
  task automatic rx_byte(logic [7:0] v, bit bad);
    for (int i = 7; i >= 0; i--) rx_bit(v[i]);
    rx_bit((~^v) ^ bad);
  endtask
  task automatic to_listen();
    while (q.size() != 0) @(negedge clk);
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog all requirements actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  logic [7:0] v;
  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 tone_out", int'(tone_out), 0);
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 err", int'(err), 0);
    rd(4'h8, v); chk("R1 reply count", int'(v), 0);

    wr(4'hA, 8'h01); repeat (40) @(negedge clk);     // R2 continuous tone
    wr(4'h8, 8'h03); repeat (40) @(negedge clk);     // R2 divider change
    wr(4'hA, 8'h03); repeat (10) @(negedge clk);     // R3 pol high
    wr(4'hA, 8'h00); wr(4'h8, 8'h02); repeat (20) @(negedge clk);

    wr(4'h0, 8'hE2); wr(4'h1, 8'h10); wr(4'h2, 8'h38);
    wr(4'hB, 8'h42); idle_wait();                     // R4 three bytes, R5 gap
    chk("R5 done after gap", int'(done), 1);

    wr(4'h0, 8'h00); wr(4'hA, 8'h01); repeat (7) @(negedge clk);
    wr(4'hB, 8'h40); repeat (30) @(negedge clk);       // R8 tone suppressed
    wr(4'h0, 8'h55); wr(4'hB, 8'h80);                 // R7 ignored while busy
    idle_wait(); repeat (30) @(negedge clk);          // R8 resumes
    wr(4'hA, 8'h00); wr(4'hB, 8'h40); idle_wait();     // R7 buffer kept 0x00

    wr(4'hB, 8'h80); idle_wait();                      // R6 unmodulated
    wr(4'hB, 8'hC0); idle_wait();                      // R6 modulated
    chk("R6 burst no error", int'(err), 0);

    for (int i = 0; i < 8; i++) wr(4'(i), 8'(i * 29 + 7));
    wr(4'hB, 8'h47); idle_wait();                      // R4 eight bytes

    wr(4'hA, 8'h04); wr(4'h0, 8'hA1); wr(4'hB, 8'h40); to_listen();
    rx_byte(8'hE4, 0); rx_byte(8'h12, 0); idle_wait();
    rd(4'h8, v); chk("R9 count", int'(v), 2);
    rd(4'h0, v); chk("R9 byte0", int'(v), 8'hE4);
    rd(4'h1, v); chk("R9 byte1", int'(v), 8'h12);
    rd(4'h9, v); chk("R10 no parity flags", int'(v), 0);
    chk("R9 err clear", int'(err), 0);
    chk("R9 done", int'(done), 1);

    wr(4'hB, 8'h40); to_listen();
    rx_byte(8'h33, 0); rx_byte(8'hC4, 1); idle_wait();
    rd(4'h9, v); chk("R10 parity flags", int'(v), 8'h02);
    chk("R10 err", int'(err), 1);
    rd(4'h1, v); chk("R10 byte kept", int'(v), 8'hC4);

    wr(4'hB, 8'h40); to_listen();
    for (int i = 0; i < 9; i++) rx_byte(8'(i * 17 + 3), 0);
    idle_wait();
    rd(4'h8, v); chk("R11 count saturates", int'(v), 8);
    for (int i = 0; i < 8; i++) begin
      rd(4'(i), v); chk("R11 stored byte", int'(v), (i * 17 + 3) & 255);
    end
    chk("R11 overflow no err", int'(err), 0);

    wr(4'hB, 8'h40); to_listen();
    rx_byte(8'h5A, 0); rx_bit(1); rx_bit(0); rx_bit(1); rx_bit(1); idle_wait();
    rd(4'h8, v); chk("R11 truncated count", int'(v), 1);
    rd(4'h0, v); chk("R11 truncated byte0", int'(v), 8'h5A);
    chk("R11 truncated err", int'(err), 1);

    wr(4'hB, 8'h40); idle_wait();
    chk("R12 timeout err", int'(err), 1);
    chk("R12 timeout done", int'(done), 1);
    rd(4'h8, v); chk("R12 count zero", int'(v), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule